// File: doc/BRIEF.md
# DSCP Priority Override Map

This block keeps, for one switch port, a 64-entry table indexed by the 6-bit DSCP code of an IP frame. Each entry can replace the frame's queue priority and its frame priority, and it carries a yellow-colour marking. Each entry has its own disable flag for each of the two replacements. When a replacement is disabled, the lookup falls back to the port-default priority, which arrives on an input next to the lookup request.

Software reaches the table through a single 16-bit indirect register. A write with the commit bit clear only loads the entry pointer. A read strobe then returns the whole selected entry one cycle later. A write with the commit bit set replaces every field of the entry that the pointer field of that same write names.

A small sequencer tracks the access phase. Its enumerated states are `ACC_IDLE`, `ACC_PTR` and `ACC_RESP`:

| From | Event | To |
|------|-------|----|
| any state | pointer-load write | `ACC_PTR` |
| any state | commit write | `ACC_IDLE` |
| any state | read strobe with no write | `ACC_RESP` |
| `ACC_RESP` | no access | `ACC_PTR` |
| `ACC_IDLE` or `ACC_PTR` | no access | unchanged |

A lookup port answers one cycle after each request with the selected queue priority, the selected frame priority, the yellow flag, and a hit flag for each replacement.

Top module: `dscp_prio_map`

## Requirements
- R1: After reset, every entry has both disable flags set (bits 7 and 3) and every other field zero, so a read of entry d returns d<<9 | 0x0088. `acc_rvalid` and `lk_ack` are 0 after reset.
- R2: A write with bit 15 clear loads the pointer from bits 14:9 and changes no entry. Its bits 8:0 are ignored.
- R3: One cycle after a read strobe with no write, `acc_rvalid` is 1 for one cycle. `acc_rdata` then holds: bit 15 = 0, bits 14:9 = pointer, bit 8 = yellow, bit 7 = queue-override disable, bits 6:4 = queue priority, bit 3 = frame-override disable, bits 2:0 = frame priority.
- R4: A write with bit 15 set replaces all five fields of the entry named by its bits 14:9, using the layout of R3. It also sets the pointer to that value.
- R5: One cycle after `lk_req`, `lk_ack` is 1. If the entry's queue disable is 0, `lk_qpri` is the entry's queue priority and `lk_q_hit` is 1. Otherwise `lk_qpri` is the `lk_dflt_q` value from the request cycle and `lk_q_hit` is 0.
- R6: The frame priority follows the same rule as R5, using the frame disable flag, `lk_dflt_f` and `lk_f_hit`.
- R7: `lk_yellow` is the entry's yellow bit, whatever the state of the disable flags.
- R8: A lookup issued in the same cycle as a commit write to the same entry returns the old contents. A lookup in the following cycle returns the new contents.
- R9: When a write and a read strobe arrive in the same cycle, the write takes effect and the read is dropped: `acc_rvalid` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Access register write strobe |
| acc_rd | input | 1 | Access register read strobe |
| acc_wdata | input | 16 | Access register write data |
| acc_rdata | output | 16 | Access register read data |
| acc_rvalid | output | 1 | Read data valid pulse |
| lk_req | input | 1 | Lookup request |
| lk_dscp | input | 6 | DSCP code to look up |
| lk_dflt_q | input | 3 | Port-default queue priority |
| lk_dflt_f | input | 3 | Port-default frame priority |
| lk_ack | output | 1 | Lookup result valid |
| lk_qpri | output | 3 | Selected queue priority |
| lk_fpri | output | 3 | Selected frame priority |
| lk_yellow | output | 1 | Yellow flag of the entry |
| lk_q_hit | output | 1 | Queue priority came from the entry |
| lk_f_hit | output | 1 | Frame priority came from the entry |

## Verification
All results are due exactly one clock edge after their stimulus: read data and `acc_rvalid` after the read strobe, lookup outputs after `lk_req`, and new entry contents after a commit write. The bench drives each stimulus on a falling edge and drops it on the next falling edge, so exactly one rising edge lies between stimulus and sampling. It samples on that second falling edge. For the same-cycle cases (R8, R9), the bench raises both strobes on one falling edge. It checks the outcome on the next falling edge, and then checks again on the cycle after that.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
    localparam int PTR_W   = 6;
    localparam int PRI_W   = 3;
    localparam int REG_W   = 16;
    localparam int N_ENT   = 1 << PTR_W;
    localparam int UPD_BIT = 15;
    localparam int PTR_LSB = 9;
    localparam int YEL_BIT = 8;
    localparam int DQ_BIT  = 7;
    localparam int Q_LSB   = 4;
    localparam int DF_BIT  = 3;
    localparam int F_LSB   = 0;

    typedef struct packed {
        logic             yellow;
        logic             dis_q;
        logic [PRI_W-1:0] qpri;
        logic             dis_f;
        logic [PRI_W-1:0] fpri;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    localparam ent_t RST_ENT = '{yellow: 1'b0, dis_q: 1'b1, qpri: '0,
                                 dis_f: 1'b1, fpri: '0};

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_PTR  = 2'd1,
        ACC_RESP = 2'd2
    } acc_st_t;

    function automatic ent_t word_to_ent(input logic [REG_W-1:0] w);
        ent_t e;
        e.yellow = w[YEL_BIT];
        e.dis_q  = w[DQ_BIT];
        e.qpri   = w[Q_LSB +: PRI_W];
        e.dis_f  = w[DF_BIT];
        e.fpri   = w[F_LSB +: PRI_W];
        return e;
    endfunction

    function automatic logic [REG_W-1:0] ent_to_word(input logic [PTR_W-1:0] p,
                                                     input ent_t e);
        logic [REG_W-1:0] w;
        w = '0;
        w[PTR_LSB +: PTR_W] = p;
        w[YEL_BIT]          = e.yellow;
        w[DQ_BIT]           = e.dis_q;
        w[Q_LSB +: PRI_W]   = e.qpri;
        w[DF_BIT]           = e.dis_f;
        w[F_LSB +: PRI_W]   = e.fpri;
        return w;
    endfunction
endpackage

// File: rtl/dpm_table.sv
module dpm_table
    import dpm_pkg::*;
#(
    parameter int AW = PTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  ent_t          wdata,
    input  logic [AW-1:0] raddr_a,
    output ent_t          rdata_a,
    input  logic [AW-1:0] raddr_b,
    output ent_t          rdata_b
);
    localparam int DEPTH = 1 << AW;

    ent_t mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem[i] <= RST_ENT;
            end else if (we && (waddr == AW'(i))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

    // R4
    ent_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/dpm_access.sv
module dpm_access
    import dpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  logic [REG_W-1:0] wdata,
    output logic             tbl_we,
    output logic [PTR_W-1:0] tbl_waddr,
    output ent_t             tbl_wdata,
    output logic [PTR_W-1:0] tbl_raddr,
    input  ent_t             tbl_rdata,
    output logic [REG_W-1:0] rdata,
    output logic             rvalid
);
    acc_st_t          state_q, state_d;
    logic [PTR_W-1:0] ptr_q;
    logic             is_commit;
    logic             is_ptr_load;
    logic             is_read;

    assign is_commit   = wr && wdata[UPD_BIT];
    assign is_ptr_load = wr && !wdata[UPD_BIT];
    assign is_read     = rd && !wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE, ACC_PTR: begin
                if (is_commit)        state_d = ACC_IDLE;
                else if (is_ptr_load) state_d = ACC_PTR;
                else if (is_read)     state_d = ACC_RESP;
            end
            ACC_RESP: begin
                if (is_commit)        state_d = ACC_IDLE;
                else if (is_ptr_load) state_d = ACC_PTR;
                else if (is_read)     state_d = ACC_RESP;
                else                  state_d = ACC_PTR;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            rdata <= '0;
        end else begin
            if (wr) ptr_q <= wdata[PTR_LSB +: PTR_W];
            if (is_read) rdata <= ent_to_word(ptr_q, tbl_rdata);
        end
    end

    assign rvalid    = (state_q == ACC_RESP);
    assign tbl_we    = is_commit;
    assign tbl_waddr = wdata[PTR_LSB +: PTR_W];
    assign tbl_wdata = word_to_ent(wdata);
    assign tbl_raddr = ptr_q;

    // R2
    ptr_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (ptr_q == $past(wdata[PTR_LSB +: PTR_W])));
    // R3
    read_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> rvalid);
    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !rvalid);
endmodule

// File: rtl/dpm_lookup.sv
module dpm_lookup
    import dpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  ent_t             ent,
    input  logic [PRI_W-1:0] dflt_q,
    input  logic [PRI_W-1:0] dflt_f,
    output logic             ack,
    output logic [PRI_W-1:0] qpri,
    output logic [PRI_W-1:0] fpri,
    output logic             yellow,
    output logic             q_hit,
    output logic             f_hit
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack    <= 1'b0;
            qpri   <= '0;
            fpri   <= '0;
            yellow <= 1'b0;
            q_hit  <= 1'b0;
            f_hit  <= 1'b0;
        end else begin
            ack <= req;
            if (req) begin
                qpri   <= ent.dis_q ? dflt_q : ent.qpri;
                fpri   <= ent.dis_f ? dflt_f : ent.fpri;
                yellow <= ent.yellow;
                q_hit  <= !ent.dis_q;
                f_hit  <= !ent.dis_f;
            end
        end
    end

    // R5
    lookup_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ack);
    // R5
    q_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !q_hit) |-> (qpri == $past(dflt_q)));
    // R6
    f_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !f_hit) |-> (fpri == $past(dflt_f)));
endmodule

// File: rtl/dscp_prio_map.sv
module dscp_prio_map
    import dpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_wr,
    input  logic        acc_rd,
    input  logic [15:0] acc_wdata,
    output logic [15:0] acc_rdata,
    output logic        acc_rvalid,
    input  logic        lk_req,
    input  logic [5:0]  lk_dscp,
    input  logic [2:0]  lk_dflt_q,
    input  logic [2:0]  lk_dflt_f,
    output logic        lk_ack,
    output logic [2:0]  lk_qpri,
    output logic [2:0]  lk_fpri,
    output logic        lk_yellow,
    output logic        lk_q_hit,
    output logic        lk_f_hit
);
    logic             t_we;
    logic [PTR_W-1:0] t_waddr;
    ent_t             t_wdata;
    logic [PTR_W-1:0] t_raddr;
    ent_t             t_rdata_acc;
    ent_t             t_rdata_lk;

    dpm_table #(.AW(PTR_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (t_we),
        .waddr   (t_waddr),
        .wdata   (t_wdata),
        .raddr_a (t_raddr),
        .rdata_a (t_rdata_acc),
        .raddr_b (lk_dscp),
        .rdata_b (t_rdata_lk)
    );

    dpm_access u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (acc_wr),
        .rd        (acc_rd),
        .wdata     (acc_wdata),
        .tbl_we    (t_we),
        .tbl_waddr (t_waddr),
        .tbl_wdata (t_wdata),
        .tbl_raddr (t_raddr),
        .tbl_rdata (t_rdata_acc),
        .rdata     (acc_rdata),
        .rvalid    (acc_rvalid)
    );

    dpm_lookup u_lookup (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (lk_req),
        .ent    (t_rdata_lk),
        .dflt_q (lk_dflt_q),
        .dflt_f (lk_dflt_f),
        .ack    (lk_ack),
        .qpri   (lk_qpri),
        .fpri   (lk_fpri),
        .yellow (lk_yellow),
        .q_hit  (lk_q_hit),
        .f_hit  (lk_f_hit)
    );
endmodule

// File: tb/sim_dscp_prio_map.sv
module sim_dscp_prio_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        acc_rvalid;
    logic        lk_req = 1'b0;
    logic [5:0]  lk_dscp = '0;
    logic [2:0]  lk_dflt_q = '0;
    logic [2:0]  lk_dflt_f = '0;
    logic        lk_ack;
    logic [2:0]  lk_qpri;
    logic [2:0]  lk_fpri;
    logic        lk_yellow;
    logic        lk_q_hit;
    logic        lk_f_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dscp_prio_map u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // entry pattern word (bit 15 clear) for DSCP d in pattern set s
    function automatic logic [15:0] pat(input int d, input int s);
        int y, dq, q, df, f;
        y  = ((d + s) / 2) % 2;
        dq = ((d + s) % 3 == 0) ? 1 : 0;
        q  = (d * 5 + s) % 8;
        df = ((d + s) % 4 == 1) ? 1 : 0;
        f  = (d * 3 + 1 + s) % 8;
        return 16'((d << 9) | (y << 8) | (dq << 7) | (q << 4) | (df << 3) | f);
    endfunction

    // expected lookup result {q_hit, f_hit, yellow, qpri, fpri}
    function automatic logic [8:0] lk_exp(input logic [15:0] w, input int dq, input int df);
        logic qh, fh;
        logic [2:0] q, f;
        qh = !w[7];
        fh = !w[3];
        q  = qh ? w[6:4] : 3'(dq);
        f  = fh ? w[2:0] : 3'(df);
        return {qh, fh, w[8], q, f};
    endfunction

    task automatic do_wr(input logic [15:0] w);
        @(negedge clk);
        acc_wr = 1'b1;
        acc_wdata = w;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic do_rd(input string req, input logic [15:0] exp);
        @(negedge clk);
        acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        chk(req, {31'd0, acc_rvalid}, 32'd1);
        chk(req, {16'd0, acc_rdata}, {16'd0, exp});
    endtask

    task automatic do_lk(input string req, input int d, input int dq, input int df,
                         input logic [8:0] exp);
        @(negedge clk);
        lk_req = 1'b1;
        lk_dscp = 6'(d);
        lk_dflt_q = 3'(dq);
        lk_dflt_f = 3'(df);
        @(negedge clk);
        lk_req = 1'b0;
        chk(req, {31'd0, lk_ack}, 32'd1);
        chk(req, {23'd0, lk_q_hit, lk_f_hit, lk_yellow, lk_qpri, lk_fpri}, {23'd0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of the outputs
        chk("R1", {30'd0, acc_rvalid, lk_ack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {30'd0, acc_rvalid, lk_ack}, 32'd0);

        // R1 R2 R3 R5 R6 R7: sweep of reset contents, pointer load with junk low bits
        for (int d = 0; d < 64; d++) begin
            do_wr(16'((d << 9) | 9'h1FF));
            do_rd("R1_R2_R3", 16'((d << 9) | 16'h0088));
            do_lk("R5_R6_R7", d, d % 8, (d + 3) % 8, lk_exp(16'(16'h0088), d % 8, (d + 3) % 8));
        end

        // R4: commit every entry, then read back and look up
        for (int d = 0; d < 64; d++) begin
            do_wr(16'h8000 | pat(d, 0));
        end
        for (int d = 0; d < 64; d++) begin
            do_wr(16'(d << 9));
            do_rd("R4_R3", pat(d, 0));
            do_lk("R5_R6_R7", d, 7 - (d % 8), d % 8, lk_exp(pat(d, 0), 7 - (d % 8), d % 8));
        end

        // R2: pointer load with mixed low bits leaves entry 20 intact
        do_wr(16'((20 << 9) | 9'h0A5));
        do_rd("R2", pat(20, 0));

        // R4: a commit also moves the pointer
        do_wr(16'h8000 | pat(9, 1));
        do_rd("R4", pat(9, 1));

        // R8: lookup in the same cycle as a commit to the same entry
        @(negedge clk);
        acc_wr = 1'b1;
        acc_wdata = 16'h8000 | 16'((5 << 9) | (1 << 8) | (6 << 4) | 2);
        lk_req = 1'b1;
        lk_dscp = 6'd5;
        lk_dflt_q = 3'd1;
        lk_dflt_f = 3'd4;
        @(negedge clk);
        acc_wr = 1'b0;
        lk_req = 1'b0;
        chk("R8", {23'd0, lk_q_hit, lk_f_hit, lk_yellow, lk_qpri, lk_fpri},
            {23'd0, lk_exp(pat(5, 0), 1, 4)});
        do_lk("R8", 5, 1, 4, lk_exp(16'((5 << 9) | (1 << 8) | (6 << 4) | 2), 1, 4));

        // R9: write and read strobe together; read dropped, write applied
        @(negedge clk);
        acc_wr = 1'b1;
        acc_rd = 1'b1;
        acc_wdata = 16'h8000 | pat(33, 2);
        @(negedge clk);
        acc_wr = 1'b0;
        acc_rd = 1'b0;
        chk("R9", {31'd0, acc_rvalid}, 32'd0);
        do_rd("R9", pat(33, 2));

        // R5 R6: re-disable both overrides on an entry, fallback returns
        do_wr(16'h8000 | 16'((40 << 9) | 16'h0188));
        do_lk("R5_R6_R7", 40, 6, 3, {1'b0, 1'b0, 1'b1, 3'd6, 3'd3});
        do_lk("R5_R6", 41, 2, 5, lk_exp(pat(41, 0), 2, 5));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule